// File: doc/BRIEF.md
# Byte-Commanded JTAG Scan Engine

This block sits between a byte-wide host write port and a JTAG target, and turns single-byte commands into complete TAP activity. A byte written with the address strobe is a command. Some commands set up the engine: the reset pins, the engine enables, the TCK divider and a one-shot partial length. Others run clocked work: a five-step TMS walk, or a burst of one to four idle clocks. A byte written with the data strobe shifts up to eight TDI bits, least significant first, and collects the TDO bits returned by the target. The host reads two values at any time: a status byte whose top bit shows that the engine is clocking, and the readback byte holding the captured TDO bits.

The engine is built around a three-state machine. `ST_IDLE` waits for work and holds TCK low. `ST_LOW` holds TCK low for one half period and ends with a rising edge, at which TDO is sampled. `ST_HIGH` holds TCK high for one half period and ends with a falling edge. From `ST_HIGH` the machine goes back to `ST_LOW` when bits remain, and to `ST_IDLE` after the last bit. An accepted clocking command or data write moves the machine from `ST_IDLE` to `ST_LOW` and presents the first TMS/TDI value at once.

Any write that arrives while the machine is out of `ST_IDLE` is dropped. If the address strobe and the data strobe are both raised in the same cycle, only the address write is taken.

Top module: `jtag_scan_engine`

## Requirements
- R1: An address byte whose bits 7:4 are 0000 sets the reset pins. Bit 2 asserts TRST and bit 0 asserts SRST. Bit 3 set makes TRST push-pull; clear makes it open-drain. Bit 1 set makes SRST open-drain; clear makes it push-pull. A push-pull pin has its enable at 1 and its level low when asserted and high otherwise. An open-drain pin has its level at 0 and its enable equal to the assertion. After reset all four bits are 0.
- R2: An address byte whose bits 7:4 are 0001 sets the JTAG enable from bit 2 and the adaptive-clock mode output from bit 1. Both are 0 after reset.
- R3: An address byte whose bits 7:4 are 0010 loads the divider from bits 3:0. TCK is then high for divider+1 clocks and low for divider+1 clocks. The divider is 0 after reset.
- R4: An address byte whose bits 7:4 are 0011 makes the next accepted data write shift (bits 2:0)+1 bits. The write after that shifts 8 bits again.
- R5: A data write shifts its byte onto TDI, least significant bit first, with TMS at 0. The readback starts at zero, and each sampled TDO bit enters at bit 7 while the contents move right. After n bits the TDO bits sit in the top n bits, with the first one lowest, and the low bits are 0.
- R6: An address byte whose bits 7:6 are 01 runs 5 TCK cycles. TMS takes bits 4:0 in order, LSB first, and TDI is held at bit 5. Afterwards the readback is bit 7 = the TDO of the first cycle, with all other bits 0.
- R7: An address byte with bit 7 set runs (bits 5:4)+1 TCK cycles with TMS at 0 and leaves the readback unchanged.
- R8: Status bit 7 reads 1 from the clock after an accepted clocking write until the last falling TCK edge. It reads 0 otherwise. Status bits 6:0 always read 0.
- R9: Every address or data write that arrives while status bit 7 is 1 has no effect.
- R10: While the JTAG enable is 0, TCK and TMS stay low, and TMS walks, idle bursts and data writes produce no clocks.
- R11: TMS and TDI change only while TCK is low. TCK is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wdata | input | 8 | Byte written by the host |
| addr_we | input | 1 | Command (address) write strobe, one cycle |
| data_we | input | 1 | Data write strobe, one cycle |
| status_o | output | 8 | Status byte, bit 7 = busy |
| readback_o | output | 8 | Captured TDO bits |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |
| trst_n_o | output | 1 | TRST level (active low) |
| trst_oe_o | output | 1 | TRST output enable |
| srst_n_o | output | 1 | SRST level (active low) |
| srst_oe_o | output | 1 | SRST output enable |
| rtck_mode_o | output | 1 | Adaptive-clock mode enable |

## Verification
The assertions rely on the host raising each strobe for a single cycle, and on the clocking commands reaching the engine only once it is enabled. Under those conditions every excursion from `ST_IDLE` is a complete, well-formed bit sequence. The bench keeps to this by driving inputs at the falling clock edge. It waits for status bit 7 to clear before each new operation, except in the scenario that deliberately writes during a busy period to check that such writes are dropped. The bench's model target returns TDO bits from a pattern that it advances on each rising TCK edge, so the expected readback follows from the pattern alone.

// File: rtl/jtag_eng_pkg.sv
package jtag_eng_pkg;
    localparam int BYTE_W  = 8;
    localparam int DIV_W   = 4;
    localparam int CNT_W   = 4;
    localparam int LEN_W   = 3;
    localparam int WALK_N  = 5;

    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} eng_state_t;

    typedef enum logic [2:0] {
        CMD_PINS, CMD_CTRL, CMD_DIV, CMD_LEN, CMD_WALK, CMD_IDLE
    } cmd_kind_t;

    typedef enum logic [1:0] {OP_DATA, OP_WALK, OP_IDLE} op_kind_t;
endpackage

// File: rtl/jtag_cmd_decode.sv
module jtag_cmd_decode
    import jtag_eng_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] cmd_i,
    output cmd_kind_t    kind_o
);
    always_comb begin
        if (cmd_i[W-1]) begin
            kind_o = CMD_IDLE;
        end else if (cmd_i[W-2]) begin
            kind_o = CMD_WALK;
        end else begin
            unique case (cmd_i[W-3:W-4])
                2'd0:    kind_o = CMD_PINS;
                2'd1:    kind_o = CMD_CTRL;
                2'd2:    kind_o = CMD_DIV;
                default: kind_o = CMD_LEN;
            endcase
        end
    end
endmodule

// File: rtl/jtag_half_tick.sv
module jtag_half_tick #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [DW-1:0] div_i,
    output logic          tick_o
);
    logic [DW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run_i || tick_o)  cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/jtag_pin_style.sv
module jtag_pin_style (
    input  logic assert_i,
    input  logic push_pull_i,
    output logic level_n_o,
    output logic oe_o
);
    always_comb begin
        if (push_pull_i) begin
            oe_o      = 1'b1;
            level_n_o = !assert_i;
        end else begin
            oe_o      = assert_i;
            level_n_o = 1'b0;
        end
    end
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
    import jtag_eng_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int DW = DIV_W,
    parameter int CW = CNT_W,
    parameter int LW = LEN_W,
    parameter int WN = WALK_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] host_wdata,
    input  logic         addr_we,
    input  logic         data_we,
    output logic [W-1:0] status_o,
    output logic [W-1:0] readback_o,
    output logic         tck_o,
    output logic         tms_o,
    output logic         tdi_o,
    input  logic         tdo_i,
    output logic         trst_n_o,
    output logic         trst_oe_o,
    output logic         srst_n_o,
    output logic         srst_oe_o,
    output logic         rtck_mode_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(W);
    localparam logic [CW-1:0] WALK_CNT = CW'(WN);

    eng_state_t     state_q, state_d;
    op_kind_t       op_q;
    cmd_kind_t      kind;
    logic           busy, half_tick, last_bit;
    logic           take_addr, take_data;
    logic           start_data, start_walk, start_idle, start_any;
    logic [CW-1:0]  bits_left_q, plen_q;
    logic           plen_vld_q;
    logic [W-1:0]   shreg_q, rb_q;
    logic [DW-1:0]  div_q;
    logic [3:0]     pins_q;
    logic           en_q, rtck_q, first_q, tdi_hold_q;
    logic           tck_q, tms_q, tdi_q;

    jtag_cmd_decode #(.W(W)) dec_i (.cmd_i(host_wdata), .kind_o(kind));

    jtag_half_tick #(.DW(DW)) tick_i (
        .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div_q), .tick_o(half_tick)
    );

    jtag_pin_style trst_i (
        .assert_i(pins_q[2]), .push_pull_i(pins_q[3]),
        .level_n_o(trst_n_o), .oe_o(trst_oe_o)
    );
    jtag_pin_style srst_i (
        .assert_i(pins_q[0]), .push_pull_i(!pins_q[1]),
        .level_n_o(srst_n_o), .oe_o(srst_oe_o)
    );

    assign busy       = (state_q != ST_IDLE);
    assign last_bit   = (bits_left_q == CW'(1));
    assign take_addr  = addr_we && !busy;
    assign take_data  = data_we && !addr_we && !busy;
    assign start_data = take_data && en_q;
    assign start_walk = take_addr && en_q && (kind == CMD_WALK);
    assign start_idle = take_addr && en_q && (kind == CMD_IDLE);
    assign start_any  = start_data || start_walk || start_idle;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_any) state_d = ST_LOW;
            ST_LOW:  if (half_tick) state_d = ST_HIGH;
            ST_HIGH: if (half_tick) state_d = last_bit ? ST_IDLE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;  bits_left_q <= '0;  plen_q <= '0;  plen_vld_q <= 1'b0;
            shreg_q <= '0;    rb_q <= '0;         div_q <= '0;   pins_q <= '0;
            en_q <= 1'b0;     rtck_q <= 1'b0;     first_q <= 1'b0; tdi_hold_q <= 1'b0;
            tck_q <= 1'b0;    tms_q <= 1'b0;      tdi_q <= 1'b0;
        end else begin
            if (take_addr) begin
                unique case (kind)
                    CMD_PINS: pins_q <= host_wdata[3:0];
                    CMD_CTRL: begin en_q <= host_wdata[2]; rtck_q <= host_wdata[1]; end
                    CMD_DIV:  div_q <= host_wdata[DW-1:0];
                    CMD_LEN:  begin
                        plen_q     <= CW'(host_wdata[LW-1:0]) + CW'(1);
                        plen_vld_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (start_data) begin
                op_q        <= OP_DATA;
                shreg_q     <= host_wdata;
                bits_left_q <= plen_vld_q ? plen_q : FULL_CNT;
                plen_vld_q  <= 1'b0;
                rb_q        <= '0;
                tdi_q       <= host_wdata[0];
                tms_q       <= 1'b0;
                first_q     <= 1'b1;
            end
            if (start_walk) begin
                op_q        <= OP_WALK;
                shreg_q     <= W'(host_wdata[WN-1:0]);
                bits_left_q <= WALK_CNT;
                rb_q        <= '0;
                tdi_hold_q  <= host_wdata[WN];
                tdi_q       <= host_wdata[WN];
                tms_q       <= host_wdata[0];
                first_q     <= 1'b1;
            end
            if (start_idle) begin
                op_q        <= OP_IDLE;
                bits_left_q <= CW'(host_wdata[5:4]) + CW'(1);
                tms_q       <= 1'b0;
                first_q     <= 1'b1;
            end
            if (state_q == ST_LOW && half_tick) begin
                tck_q <= 1'b1;
                if (op_q == OP_DATA || (op_q == OP_WALK && first_q))
                    rb_q <= {tdo_i, rb_q[W-1:1]};
            end
            if (state_q == ST_HIGH && half_tick) begin
                tck_q   <= 1'b0;
                first_q <= 1'b0;
                if (!last_bit) begin
                    bits_left_q <= bits_left_q - CW'(1);
                    shreg_q     <= shreg_q >> 1;
                    if (op_q == OP_DATA) tdi_q <= shreg_q[1];
                    if (op_q == OP_WALK) begin
                        tms_q <= shreg_q[1];
                        tdi_q <= tdi_hold_q;
                    end
                end
            end
        end
    end

    assign tck_o       = tck_q & en_q;
    assign tms_o       = tms_q & en_q;
    assign tdi_o       = tdi_q;
    assign status_o    = {busy, {(W-1){1'b0}}};
    assign readback_o  = rb_q;
    assign rtck_mode_o = rtck_q;

    // R9
    busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($stable(div_q) && $stable(en_q) && $stable(pins_q)));
    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !busy);
    // R11
    idle_tck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck_q);
    // R3
    tck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tck_q) |-> $past(half_tick));
    // R4
    len_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_data) |-> !plen_vld_q);
    // R8
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bits_left_q != '0 && bits_left_q <= FULL_CNT));
    // R11
    tms_low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_q && $past(tck_q)) |-> ($stable(tms_q) && $stable(tdi_q)));
endmodule

// File: tb/jtag_scan_engine_tb_top.sv
module jtag_scan_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       addr_we = 1'b0, data_we = 1'b0;
    logic [7:0] status, readback;
    logic       tck, tms, tdi, tdo;
    logic       trst_n, trst_oe, srst_n, srst_oe, rtck_mode;

    int vectors = 0, fails = 0;
    logic [7:0] rise_cnt = '0, base = '0, idx, tdo_pat = '0;
    logic [7:0] cap_tdi = '0, cap_tms = '0;
    logic       prev_tdi = 1'b0, prev_tms = 1'b0, edge_viol = 1'b0;

    always #4 clk = !clk;

    assign idx = rise_cnt - base;
    assign tdo = tdo_pat[idx[2:0]];

    jtag_scan_engine dut_i (
        .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata), .addr_we(addr_we),
        .data_we(data_we), .status_o(status), .readback_o(readback),
        .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo),
        .trst_n_o(trst_n), .trst_oe_o(trst_oe), .srst_n_o(srst_n),
        .srst_oe_o(srst_oe), .rtck_mode_o(rtck_mode)
    );

    always @(posedge tck) begin
        cap_tdi  <= {tdi, cap_tdi[7:1]};
        cap_tms  <= {tms, cap_tms[7:1]};
        rise_cnt <= rise_cnt + 8'd1;
    end

    always @(negedge clk) begin
        if ((tdi !== prev_tdi || tms !== prev_tms) && tck) edge_viol <= 1'b1;
        prev_tdi <= tdi;
        prev_tms <= tms;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic addr_wr(input logic [7:0] b);
        @(negedge clk); host_wdata = b; addr_we = 1'b1;
        @(negedge clk); addr_we = 1'b0;
    endtask

    task automatic data_wr(input logic [7:0] b);
        @(negedge clk); host_wdata = b; data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (status[7] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic run_data(input logic [7:0] d, input logic [7:0] p, input int n);
        int exp_rb;
        tdo_pat = p; base = rise_cnt;
        data_wr(d);
        chk("R8 busy status", status, 8'h80);
        wait_idle();
        @(negedge clk);
        chk("R5 clock count", idx, n);
        exp_rb = ((p & ((1 << n) - 1)) << (8 - n)) & 8'hFF;
        chk("R5 readback", readback, exp_rb);
        chk("R5 tdi bits", (cap_tdi >> (8 - n)) & ((1 << n) - 1), d & ((1 << n) - 1));
        chk("R5 tms low", (cap_tms >> (8 - n)) & ((1 << n) - 1), 0);
    endtask

    task automatic t_reset();
        chk("R8 reset status", status, 8'h00);
        chk("R5 reset readback", readback, 8'h00);
        chk("R10 reset tck/tms", {tck, tms}, 2'b00);
        chk("R1 reset trst", {trst_oe, trst_n}, 2'b00);
        chk("R1 reset srst", {srst_oe, srst_n}, 2'b11);
        chk("R2 reset rtck", rtck_mode, 1'b0);
    endtask

    task automatic t_disabled();
        base = rise_cnt;
        data_wr(8'hA5);
        chk("R10 data write while off", status, 8'h00);
        addr_wr(8'h5F);
        addr_wr(8'hB0);
        repeat (20) @(negedge clk);
        chk("R10 no clocks while off", idx, 0);
        chk("R10 tck/tms low", {tck, tms}, 2'b00);
    endtask

    task automatic t_ctrl();
        addr_wr(8'h16);
        chk("R2 rtck on", rtck_mode, 1'b1);
        addr_wr(8'h14);
        chk("R2 rtck off", rtck_mode, 1'b0);
    endtask

    task automatic t_pins();
        addr_wr(8'h05);
        chk("R1 trst od asserted", {trst_oe, trst_n}, 2'b10);
        chk("R1 srst pp asserted", {srst_oe, srst_n}, 2'b10);
        addr_wr(8'h0A);
        chk("R1 trst pp idle", {trst_oe, trst_n}, 2'b11);
        chk("R1 srst od idle", {srst_oe, srst_n}, 2'b00);
        addr_wr(8'h0F);
        chk("R1 trst pp asserted", {trst_oe, trst_n}, 2'b10);
        chk("R1 srst od asserted", {srst_oe, srst_n}, 2'b10);
        addr_wr(8'h00);
    endtask

    task automatic t_len();
        addr_wr(8'h32);
        run_data(8'h6D, 8'hB5, 3);
        run_data(8'h12, 8'hC3, 8);
        addr_wr(8'h30);
        run_data(8'hFF, 8'h01, 1);
    endtask

    task automatic run_walk(input logic [7:0] cmd, input logic [7:0] p);
        tdo_pat = p; base = rise_cnt;
        addr_wr(cmd);
        chk("R8 busy walk", status[7], 1'b1);
        wait_idle();
        @(negedge clk);
        chk("R6 walk count", idx, 5);
        chk("R6 walk tms", cap_tms[7:3], cmd[4:0]);
        chk("R6 walk tdi", cap_tdi[7:3], {5{cmd[5]}});
        chk("R6 walk readback", readback, {p[0], 7'b0});
    endtask

    task automatic run_idle(input logic [7:0] cmd, input int n);
        logic [7:0] keep;
        keep = readback; base = rise_cnt;
        addr_wr(cmd);
        wait_idle();
        @(negedge clk);
        chk("R7 idle count", idx, n);
        chk("R7 idle tms", (cap_tms >> (8 - n)) & ((1 << n) - 1), 0);
        chk("R7 readback kept", readback, keep);
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int i = 0; i < 100 && !tck; i++) @(negedge clk);
        for (int i = 0; i < 100 && tck; i++) begin hi++; @(negedge clk); end
        for (int i = 0; i < 100 && !tck; i++) begin lo++; @(negedge clk); end
    endtask

    task automatic t_div();
        int hi, lo;
        addr_wr(8'h22);
        tdo_pat = 8'h00; base = rise_cnt;
        data_wr(8'h55);
        measure(hi, lo);
        chk("R3 tck high width", hi, 3);
        chk("R3 tck low width", lo, 3);
        wait_idle();
        addr_wr(8'h20);
    endtask

    task automatic t_busy_ignore();
        int hi, lo;
        addr_wr(8'h23);
        tdo_pat = 8'hFF; base = rise_cnt;
        data_wr(8'h0F);
        addr_wr(8'h20);
        data_wr(8'h00);
        addr_wr(8'h33);
        addr_wr(8'h05);
        chk("R9 still busy", status[7], 1'b1);
        wait_idle();
        @(negedge clk);
        chk("R9 single op clocks", idx, 8);
        chk("R9 readback of first op", readback, 8'hFF);
        chk("R9 pins untouched", {trst_oe, srst_oe}, 2'b01);
        tdo_pat = 8'h00; base = rise_cnt;
        data_wr(8'hAA);
        measure(hi, lo);
        chk("R9 divider kept", hi, 4);
        wait_idle();
        @(negedge clk);
        chk("R9 length cmd dropped", idx, 8);
        addr_wr(8'h20);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_ctrl();
        t_pins();
        run_data(8'hA5, 8'h3C, 8);
        run_data(8'hFF, 8'h81, 8);
        t_len();
        run_walk(8'h75, 8'h01);
        run_walk(8'h4B, 8'hFE);
        run_idle(8'h80, 1);
        run_idle(8'hB0, 4);
        t_div();
        t_busy_ignore();
        chk("R11 tms/tdi moved only with tck low", edge_viol, 1'b0);
        chk("R11 tck low at rest", tck, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule